// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It detects the one case that operand forwarding cannot cover: an instruction that reads a register written by a load directly ahead of it. A load's data is only available once the memory stage finishes. A consumer in the very next slot therefore needs it one cycle before it exists, and the pipeline must insert a single bubble.

The unit is purely combinational. It compares each source register that the decoding instruction really reads against the destination of the instruction now in execute, but only when that instruction reads memory. On a hit it freezes the program counter and the IF/ID register. In the same cycle it asks for the control fields of the ID/EX register (register write, memory write, memory read) to be zeroed, so that a harmless bubble enters execute. The load moves on to the memory stage. On the next cycle the held instruction decodes again with the bubble ahead of it, and forwarding serves it from then on.

The register-address width and the number of source operands are parameters. A further option selects whether register 0 is a constant zero, in which case it never causes a stall.

Top module: `lu_stall_unit`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_dst_addr` is non-zero, and a source whose `id_src_used` bit is 1 equals `ex_dst_addr`, the unit stalls: `pc_wr_en`=0, `ifid_wr_en`=0, `idex_ctrl_clear`=1.
- R2: When `ex_mem_read` is 0, no stall is raised, even if a used source equals `ex_dst_addr`.
- R3: A source whose `id_src_used` bit is 0 never causes a stall, even if its address equals the load's destination.
- R4: With the constant-zero option on (the default), a load whose destination is register 0 never causes a stall.
- R5: When no used source matches, `pc_wr_en`=1, `ifid_wr_en`=1 and `idex_ctrl_clear`=0.
- R6: `pc_wr_en` and `ifid_wr_en` are always equal, and `idex_ctrl_clear` is always their complement.
- R7: In a pipeline that obeys the outputs, a load followed at once by a dependent consumer costs exactly one stall cycle, and no stall lasts two cycles in a row.
- R8: A consumer two or three slots behind a load causes no stall.
- R9: A match on any one source slot is enough. Source k sits at bits `[k*REG_AW +: REG_AW]` of `id_src_addr`, and its use flag is `id_src_used[k]`. The check holds up to the highest register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_addr | input | NUM_SRC*REG_AW | Source register addresses of the decoding instruction; source k at bits k*REG_AW upward |
| id_src_used | input | NUM_SRC | Bit k is 1 when source k is really read |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_dst_addr | input | REG_AW | Destination register of the instruction in execute |
| pc_wr_en | output | 1 | Program counter may update |
| ifid_wr_en | output | 1 | IF/ID register may load |
| idex_ctrl_clear | output | 1 | Zero the write and memory controls entering ID/EX |

## Verification
The assertions check on every evaluation that the outputs follow the detection rule: a stall on a qualified match, none without a load, none from an unused source or from a register-0 destination, and the three outputs kept consistent. Two things depend on the pipeline around the unit: that a stall lasts exactly one cycle, and that consumers further behind a load never stall. Only the bench's small pipeline model, running short instruction streams, can show these.

// File: rtl/lu_pkg.sv
package lu_pkg;

   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic idex_clr;
   } stall_ctl_t;

   function automatic stall_ctl_t mk_ctl(input logic stall);
      stall_ctl_t c;
      c.pc_we    = ~stall;
      c.ifid_we  = ~stall;
      c.idex_clr = stall;
      return c;
   endfunction

endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_AW-1:0] src_addr,
   input  logic              src_used,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] ex_dst,
   output logic              hit
);

   logic same_reg;
   assign same_reg = (src_addr == ex_dst);

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         logic dst_live;
         assign dst_live = |ex_dst;
         assign hit = src_used & ex_load & same_reg & dst_live;
      end else begin : g_zero_plain
         assign hit = src_used & ex_load & same_reg;
      end
   endgenerate

endmodule

// File: rtl/lu_stall_drive.sv
module lu_stall_drive #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] hits,
   output lu_pkg::stall_ctl_t ctl
);

   logic any_hit;
   assign any_hit = |hits;
   assign ctl     = lu_pkg::mk_ctl(any_hit);

endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
   parameter int REG_AW        = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC*REG_AW-1:0] id_src_addr,
   input  logic [NUM_SRC-1:0]        id_src_used,
   input  logic                      ex_mem_read,
   input  logic [REG_AW-1:0]         ex_dst_addr,
   output logic                      pc_wr_en,
   output logic                      ifid_wr_en,
   output logic                      idex_ctrl_clear
);

   localparam int ADDR_BITS = NUM_SRC * REG_AW;

   generate
      if (REG_AW < 1 || REG_AW > 16) begin : g_bad_aw
         $error("lu_stall_unit: REG_AW out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 8) begin : g_bad_src
         $error("lu_stall_unit: NUM_SRC out of range");
      end
      if (ADDR_BITS < 1) begin : g_bad_bits
         $error("lu_stall_unit: empty source bus");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_hit;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         lu_src_cmp #(
            .REG_AW       (REG_AW),
            .ZERO_IS_CONST(ZERO_IS_CONST)
         ) u_cmp (
            .src_addr(id_src_addr[k*REG_AW +: REG_AW]),
            .src_used(id_src_used[k]),
            .ex_load (ex_mem_read),
            .ex_dst  (ex_dst_addr),
            .hit     (src_hit[k])
         );
      end
   endgenerate

   lu_pkg::stall_ctl_t ctl;

   lu_stall_drive #(
      .NUM_SRC(NUM_SRC)
   ) u_drive (
      .hits(src_hit),
      .ctl (ctl)
   );

   assign pc_wr_en        = ctl.pc_we;
   assign ifid_wr_en      = ctl.ifid_we;
   assign idex_ctrl_clear = ctl.idex_clr;

endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
   parameter int REG_AW        = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input logic [NUM_SRC*REG_AW-1:0] id_src_addr,
   input logic [NUM_SRC-1:0]        id_src_used,
   input logic                      ex_mem_read,
   input logic [REG_AW-1:0]         ex_dst_addr,
   input logic                      pc_wr_en,
   input logic                      ifid_wr_en,
   input logic                      idex_ctrl_clear
);

   logic qual_match;
   always_comb begin
      qual_match = 1'b0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (id_src_used[k] && id_src_addr[k*REG_AW +: REG_AW] == ex_dst_addr)
            qual_match = 1'b1;
      end
   end

   always_comb begin
      // R1 / R9: qualified match on any slot stalls
      p_stall_on_match_r1: assert (!(ex_mem_read && ex_dst_addr != '0 && qual_match) || !pc_wr_en)
         else $error("stall missing on load-use match");
      p_no_load_no_stall_r2: assert (ex_mem_read || pc_wr_en)
         else $error("stall without a load in execute");
      p_unused_ignored_r3: assert (qual_match || pc_wr_en)
         else $error("stall with no used source matching");
      if (ZERO_IS_CONST) begin
         p_zero_dst_r4: assert (ex_dst_addr != '0 || pc_wr_en)
            else $error("stall on register-0 destination");
      end
      p_enables_agree_r6: assert (pc_wr_en == ifid_wr_en && idex_ctrl_clear == !pc_wr_en)
         else $error("stall outputs inconsistent");
   end

endmodule

bind lu_stall_unit lu_stall_chk #(
   .REG_AW       (REG_AW),
   .NUM_SRC      (NUM_SRC),
   .ZERO_IS_CONST(ZERO_IS_CONST)
) u_chk (
   .id_src_addr    (id_src_addr),
   .id_src_used    (id_src_used),
   .ex_mem_read    (ex_mem_read),
   .ex_dst_addr    (ex_dst_addr),
   .pc_wr_en       (pc_wr_en),
   .ifid_wr_en     (ifid_wr_en),
   .idex_ctrl_clear(idex_ctrl_clear)
);

// File: tb/sim_lu_stall_unit.sv
`timescale 1ns/1ps
module sim_lu_stall_unit;

   localparam int AW = 5;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NS*AW-1:0] id_src_addr;
   logic [NS-1:0]    id_src_used;
   logic             ex_mem_read;
   logic [AW-1:0]    ex_dst_addr;
   logic             pc_wr_en, ifid_wr_en, idex_ctrl_clear;

   lu_stall_unit #(.REG_AW(AW), .NUM_SRC(NS), .ZERO_IS_CONST(1'b1)) u0 (
      .id_src_addr(id_src_addr), .id_src_used(id_src_used),
      .ex_mem_read(ex_mem_read), .ex_dst_addr(ex_dst_addr),
      .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
      .idex_ctrl_clear(idex_ctrl_clear));

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // vector: [18] mem_read, [17:13] dst, [12:8] src0, [7:3] src1, [2:1] {used1,used0}, [0] expect stall
   localparam int NV = 10;
   localparam logic [18:0] VEC [NV] = '{
      {1'b1, 5'd1,  5'd1,  5'd2,  2'b11, 1'b1},  // R1 src0
      {1'b1, 5'd7,  5'd3,  5'd7,  2'b11, 1'b1},  // R9 src1
      {1'b0, 5'd5,  5'd5,  5'd5,  2'b11, 1'b0},  // R2
      {1'b1, 5'd5,  5'd5,  5'd9,  2'b10, 1'b0},  // R3 src0 unused
      {1'b1, 5'd9,  5'd4,  5'd9,  2'b01, 1'b0},  // R3 src1 unused
      {1'b1, 5'd0,  5'd0,  5'd0,  2'b11, 1'b0},  // R4
      {1'b1, 5'd12, 5'd3,  5'd4,  2'b11, 1'b0},  // R5
      {1'b1, 5'd31, 5'd31, 5'd0,  2'b01, 1'b1},  // R9 top register
      {1'b1, 5'd6,  5'd6,  5'd6,  2'b11, 1'b1},  // R1 both
      {1'b0, 5'd0,  5'd0,  5'd0,  2'b00, 1'b0}   // R5 idle
   };

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: outputs {pc,ifid,clr}=%b expected %b", req, act, exp);
      end
   endtask

   // instruction for the pipeline model: [17] load, [16:12] dst, [11:7] src0, [6] used0, [5:1] src1, [0] used1
   logic [17:0] ifid_ins;
   logic        ex_ld;
   logic [4:0]  ex_dst;
   bit          model_on = 1'b0;
   logic [17:0] prog [8];

   always_comb begin
      if (model_on) begin
         id_src_addr = {ifid_ins[5:1], ifid_ins[11:7]};
         id_src_used = {ifid_ins[0], ifid_ins[6]};
         ex_mem_read = ex_ld;
         ex_dst_addr = ex_dst;
      end else begin
         id_src_addr = '0;
         id_src_used = '0;
         ex_mem_read = 1'b0;
         ex_dst_addr = '0;
      end
   end

   // vector mode drives through these when model_on is 0 is not enough; use separate regs
   function automatic logic [17:0] ins(input bit ld, input int d, input int a, input bit ua,
                                       input int b, input bit ub);
      return {ld, 5'(d), 5'(a), ua, 5'(b), ub};
   endfunction

   task automatic run_prog(input string req, input int n, input int exp_stalls);
      int pc = 0;
      int stalls = 0;
      int run = 0;
      int max_run = 0;
      ifid_ins = '0; ex_ld = 1'b0; ex_dst = '0;
      for (int cyc = 0; cyc < n + 6; cyc++) begin
         @(negedge clk);
         if (!pc_wr_en) begin
            stalls++; run++;
            if (run > max_run) max_run = run;
         end else run = 0;
         @(posedge clk);
         if (!pc_wr_en) begin
            ex_ld = 1'b0; ex_dst = '0;            // bubble into execute
         end else begin
            ex_ld  = ifid_ins[17];
            ex_dst = ifid_ins[16:12];
            ifid_ins = (pc < n) ? prog[pc] : 18'd0;
            pc++;
         end
      end
      check({req, " stall count"}, 3'(stalls), 3'(exp_stalls));
      check("R7 single-cycle stall", 3'(max_run > 1), 3'd0);
   endtask

   logic [18:0] v;
   logic [2:0]  expv;

   initial begin
      model_on = 1'b1;
      ifid_ins = '0; ex_ld = 1'b0; ex_dst = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R5 reset state", {pc_wr_en, ifid_wr_en, idex_ctrl_clear}, 3'b110);
      rst_n = 1'b1;

      // table walk, driven through the model's decode/execute registers
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         @(posedge clk);
         ex_ld    = v[18];
         ex_dst   = v[17:13];
         ifid_ins = {1'b0, 5'd0, v[12:8], v[1], v[7:3], v[2]};
         @(negedge clk);
         expv = v[0] ? 3'b001 : 3'b110;   // R6 encoding
         check($sformatf("R1/R2/R3/R4/R5/R6/R9 vec%0d", i),
               {pc_wr_en, ifid_wr_en, idex_ctrl_clear}, expv);
      end

      // load then immediate consumer, then later consumers: one stall
      prog[0] = ins(1, 1, 2, 1, 0, 0);
      prog[1] = ins(0, 4, 1, 1, 2, 1);
      prog[2] = ins(0, 3, 5, 1, 1, 1);
      prog[3] = ins(0, 6, 1, 1, 2, 1);
      run_prog("R7 load-use", 4, 1);

      // consumer two slots behind, then three slots behind
      prog[0] = ins(1, 2, 3, 1, 0, 0);
      prog[1] = ins(0, 7, 8, 1, 9, 1);
      prog[2] = ins(0, 10, 2, 1, 0, 0);
      prog[3] = ins(1, 11, 3, 1, 0, 0);
      prog[4] = ins(0, 12, 4, 1, 0, 0);
      prog[5] = ins(0, 13, 4, 1, 5, 1);
      prog[6] = ins(0, 14, 0, 0, 11, 1);
      run_prog("R8 distant consumer", 7, 0);

      // load to register 0 followed by reader of register 0
      prog[0] = ins(1, 0, 2, 1, 0, 0);
      prog[1] = ins(0, 5, 0, 1, 0, 1);
      run_prog("R4 zero destination", 2, 0);

      // chained loads: each followed by a dependent
      prog[0] = ins(1, 3, 1, 1, 0, 0);
      prog[1] = ins(1, 4, 3, 1, 0, 0);
      prog[2] = ins(0, 5, 0, 0, 4, 1);
      run_prog("R7 chained loads", 3, 2);

      // immediate-form consumer whose unused field names the load target
      prog[0] = ins(1, 8, 1, 1, 0, 0);
      prog[1] = ins(0, 9, 2, 1, 8, 0);
      run_prog("R3 immediate form", 2, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule